// File: doc/BRIEF.md
# I2C Byte Master Engine

This block carries out a single I2C byte transfer each time it is asked. A request presents a 4-bit set of flags and a byte. The flags choose whether a START condition comes first, whether the byte is sent or one is received, and whether a STOP condition follows the acknowledge bit. The engine drives the clock line. It drives the data line through a separate output value and output enable, so that the chip's pad can model an open-drain line. It samples the data line at the middle of each clock-high phase and changes it only at the middle of each clock-low phase, apart from the START and STOP edges.

A controller strings whole transactions together from these byte operations. It uses START plus WRITE for the address byte, plain WRITE for register or payload bytes, and START plus READ for a repeated start. READ plus STOP marks the last byte read, and the engine answers that byte with a not-acknowledge. Each bit lasts a fixed number of system clocks, `PERIOD` (250 by default). When the engine returns to idle it pulses `op_done` for one cycle. The received byte is then on `rx_byte` and the slave's acknowledge bit is on `slave_nack`.

States: `ST_IDLE`, `ST_START`, `ST_WRITE`, `ST_RACK` (the slave acknowledges), `ST_READ`, `ST_SACK` (the master acknowledges) and `ST_STOP`. The transitions are:

- IDLE→START: on an accepted request with the START flag set.
- IDLE→WRITE and IDLE→READ: on an accepted request without the START flag.
- START→WRITE and START→READ: at the end of the START bit.
- WRITE→RACK and READ→SACK: after the eighth bit.
- RACK→STOP and SACK→STOP: when the STOP flag is set.
- RACK→IDLE and SACK→IDLE: when the STOP flag is clear.
- STOP→IDLE: after one bit period.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_drive` is 0, `sda_out` is 1 and `op_done` is 0.
- R2: The flag bits are: bit 0 START, bit 1 WRITE, bit 2 READ and bit 3 STOP. A request in IDLE is accepted only if WRITE or READ is set; any other request leaves the engine idle, with no `op_done` and no change on `scl_o`. When both WRITE and READ are set, the byte is written.
- R3: A request made while an operation is in progress is ignored, and the operation finishes exactly as first commanded.
- R4: `op_done` is high for exactly one cycle, in the cycle (S+9+P)·PERIOD clocks after the edge that accepted the request. S and P are 1 when the START or STOP flag is set, and 0 otherwise.
- R5: `scl_o` falls on acceptance and rises once per bit period, (S+9+P) times in all. Each high phase lasts PERIOD/2 clocks. After a STOP, `scl_o` stays high; after an operation without a STOP, it stays low.
- R6: The data line falls while `scl_o` is high exactly once if the START flag is set, and never otherwise. It rises while `scl_o` is high exactly once if the STOP flag is set, and never otherwise.
- R7: In a write, the engine drives the 8 bits of `tx_byte` MSB first, with `sda_drive` high. Each bit stays stable for the whole high phase of its clock pulse.
- R8: In the acknowledge bit of a write, `sda_drive` is 0 and `slave_nack` takes the data line value sampled in that bit (0 = acknowledged).
- R9: In a read, `sda_drive` is 0 for all 8 data bits. Afterwards `rx_byte` holds the sampled bits, with the first one received as the MSB.
- R10: In the acknowledge bit of a read, `sda_drive` is 1 and the engine drives 1 if STOP is set and 0 if it is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_req | input | 1 | Request a byte operation (taken only in IDLE) |
| op_flags | input | 4 | bit0 START, bit1 WRITE, bit2 READ, bit3 STOP |
| tx_byte | input | BITS | Byte to send, latched on acceptance |
| op_done | output | 1 | One-cycle pulse when the engine returns to IDLE |
| rx_byte | output | BITS | Last byte received |
| slave_nack | output | 1 | Acknowledge bit sampled from the slave (1 = not acknowledged) |
| scl_o | output | 1 | I2C clock |
| sda_in | input | 1 | Sampled data line |
| sda_out | output | 1 | Value driven onto the data line when enabled |
| sda_drive | output | 1 | Data line output enable |

## Verification
On every cycle, the assertions check the following:
- the ranges of the period and bit counters;
- the one-cycle `op_done` pulse;
- that the latched flags stay frozen while the engine is busy;
- that flag sets without WRITE or READ are refused;
- that written and acknowledge data stays stable while the clock is high;
- that the data line is released during received bits;
- that the clock is high after a STOP.

Only the bench scenarios can show the end-to-end behaviour. That covers the exact latency of each flag combination and the number and width of clock pulses. It also covers detecting START and STOP edges on the resolved line, the bit order in both directions, the acknowledge values and whether a busy request leaves any trace.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    localparam int CMD_W  = 4;
    localparam int FL_STA = 0;
    localparam int FL_WR  = 1;
    localparam int FL_RD  = 2;
    localparam int FL_STO = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_WRITE = 3'd2,
        ST_RACK  = 3'd3,
        ST_READ  = 3'd4,
        ST_SACK  = 3'd5,
        ST_STOP  = 3'd6
    } eng_state_t;

endpackage

// File: rtl/i2c_eng_timer.sv
module i2c_eng_timer #(
    parameter int PERIOD = 250,
    parameter int BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic byte_phase,
    output logic mid_low,
    output logic rise_tick,
    output logic mid_high,
    output logic period_end,
    output logic state_end
);
    localparam int HALF   = PERIOD / 2;
    localparam int MID_LO = HALF / 2;
    localparam int MID_HI = HALF + HALF / 2;
    localparam int CW     = $clog2(PERIOD);
    localparam int BW     = $clog2(BITS) + 1;
    localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;
    logic [BW-1:0] bcnt;
    logic [BW-1:0] bit_lim;

    assign bit_lim    = byte_phase ? BW'(BITS - 1) : '0;
    assign period_end = run && (cnt == LAST_C);
    assign state_end  = period_end && (bcnt == bit_lim);
    assign mid_low    = run && (cnt == CW'(MID_LO));
    assign rise_tick  = run && (cnt == CW'(HALF - 1));
    assign mid_high   = run && (cnt == CW'(MID_HI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST_C) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (!run || state_end) begin
            bcnt <= '0;
        end else if (period_end) begin
            bcnt <= bcnt + 1'b1;
        end
    end

    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_C) else $error("period counter out of range"); // R5

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (cnt == '0 && bcnt == '0)) else $error("counters run in idle"); // R5

    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bcnt <= bit_lim)) else $error("bit counter out of range"); // R4

endmodule

// File: rtl/i2c_eng_shift.sv
module i2c_eng_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] din,
    input  logic            tx_shift,
    input  logic            rx_shift,
    input  logic            rx_bit,
    output logic            tx_msb,
    output logic [BITS-1:0] rx_data
);
    logic [BITS-1:0] tx_sr;

    assign tx_msb = tx_sr[BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '1;
        end else if (load) begin
            tx_sr <= din;
        end else if (tx_shift) begin
            tx_sr <= {tx_sr[BITS-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (rx_shift) begin
            rx_data <= {rx_data[BITS-2:0], rx_bit};
        end
    end

    AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tx_shift) |=> $stable(tx_sr)) else $error("tx shifter moved"); // R7

endmodule

// File: rtl/i2c_eng_fsm.sv
module i2c_eng_fsm
    import i2c_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CMD_W-1:0] flags,
    input  logic             state_end,
    output eng_state_t       state,
    output eng_state_t       nxt,
    output logic [CMD_W-1:0] flags_q,
    output logic             accept,
    output logic             done
);
    assign accept = (state == ST_IDLE) && req && (flags[FL_WR] || flags[FL_RD]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (flags[FL_STA])     nxt = ST_START;
                    else if (flags[FL_WR]) nxt = ST_WRITE;
                    else                   nxt = ST_READ;
                end
            end
            ST_START: if (state_end) nxt = flags_q[FL_WR] ? ST_WRITE : ST_READ;
            ST_WRITE: if (state_end) nxt = ST_RACK;
            ST_READ:  if (state_end) nxt = ST_SACK;
            ST_RACK, ST_SACK: begin
                if (state_end) nxt = flags_q[FL_STO] ? ST_STOP : ST_IDLE;
            end
            ST_STOP:  if (state_end) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            done    <= 1'b0;
        end else begin
            if (accept) flags_q <= flags;
            done <= (state != ST_IDLE) && (nxt == ST_IDLE);
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R4

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(flags_q)) else $error("flags changed while busy"); // R3

    AST_REFUSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !flags[FL_WR] && !flags[FL_RD]) |=> (state == ST_IDLE)) else $error("empty request accepted"); // R2

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int PERIOD = 250,
    parameter int BITS   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_req,
    input  logic [CMD_W-1:0] op_flags,
    input  logic [BITS-1:0]  tx_byte,
    output logic             op_done,
    output logic [BITS-1:0]  rx_byte,
    output logic             slave_nack,
    output logic             scl_o,
    input  logic             sda_in,
    output logic             sda_out,
    output logic             sda_drive
);
    eng_state_t       state;
    eng_state_t       nxt;
    logic [CMD_W-1:0] flags_q;
    logic             accept;
    logic             run;
    logic             byte_phase;
    logic             mid_low;
    logic             rise_tick;
    logic             mid_high;
    logic             period_end;
    logic             state_end;
    logic             tx_msb;
    logic             drive_next;

    assign run        = (state != ST_IDLE);
    assign byte_phase = (state == ST_WRITE) || (state == ST_READ);

    i2c_eng_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (op_req),
        .flags     (op_flags),
        .state_end (state_end),
        .state     (state),
        .nxt       (nxt),
        .flags_q   (flags_q),
        .accept    (accept),
        .done      (op_done)
    );

    i2c_eng_timer #(.PERIOD(PERIOD), .BITS(BITS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .byte_phase (byte_phase),
        .mid_low    (mid_low),
        .rise_tick  (rise_tick),
        .mid_high   (mid_high),
        .period_end (period_end),
        .state_end  (state_end)
    );

    i2c_eng_shift #(.BITS(BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .din      (tx_byte),
        .tx_shift (state == ST_WRITE && mid_low),
        .rx_shift (state == ST_READ && mid_high),
        .rx_bit   (sda_in),
        .tx_msb   (tx_msb),
        .rx_data  (rx_byte)
    );

    // clock line: low on leaving idle, high from mid-period, low at period end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_o <= 1'b1;
        end else if (accept) begin
            scl_o <= 1'b0;
        end else if (run) begin
            if (rise_tick) begin
                scl_o <= 1'b1;
            end else if (period_end && state != ST_STOP) begin
                scl_o <= 1'b0;
            end
        end
    end

    // data line value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_out <= 1'b1;
        end else begin
            unique case (state)
                ST_START: begin
                    if (mid_low)       sda_out <= 1'b1;
                    else if (mid_high) sda_out <= 1'b0;
                end
                ST_WRITE: if (mid_low) sda_out <= tx_msb;
                ST_SACK:  if (mid_low) sda_out <= flags_q[FL_STO];
                ST_STOP: begin
                    if (mid_low)       sda_out <= 1'b0;
                    else if (mid_high) sda_out <= 1'b1;
                end
                default: sda_out <= sda_out;
            endcase
        end
    end

    // output enable follows the state being entered
    always_comb begin
        unique case (nxt)
            ST_START, ST_WRITE, ST_SACK, ST_STOP: drive_next = 1'b1;
            default:                              drive_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_drive <= 1'b0;
        end else begin
            sda_drive <= drive_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slave_nack <= 1'b1;
        end else if (state == ST_RACK && mid_high) begin
            slave_nack <= sda_in;
        end
    end

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && (state == ST_WRITE || state == ST_SACK)
         && $past(state) == state) |-> $stable(sda_out)) else $error("data moved while clock high"); // R7

    AST_RELEASE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ || state == ST_RACK) |-> !sda_drive) else $error("line driven while slave talks"); // R9

    AST_DRIVE_SACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SACK) |-> sda_drive) else $error("master ack not driven"); // R10

    AST_SCL_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_STOP) |-> scl_o) else $error("clock low after stop"); // R5

    AST_SCL_FALLS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !scl_o) else $error("clock not low after accept"); // R5

endmodule

// File: tb/i2c_byte_engine_test.sv
`timescale 1ns/1ps
module i2c_byte_engine_test;
    localparam int P    = 20;
    localparam int HALF = P / 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_req;
    logic [3:0] op_flags;
    logic [7:0] tx_byte;
    logic       op_done;
    logic [7:0] rx_byte;
    logic       slave_nack;
    logic       scl_o;
    logic       sda_out;
    logic       sda_drive;
    logic       slave_q;
    logic       line;

    int n_cmp = 0;
    int n_bad = 0;

    // monitor state
    int   rc;
    int   slave_idx;
    int   n_start;
    int   n_stop;
    int   hi_len;
    int   hi_bad;
    logic prev_scl;
    logic prev_line;
    logic bits_seen [16];
    logic oe_seen   [16];

    // stimulus-owned
    logic       mon_clear;
    logic       active;
    logic       cur_read;
    logic       cur_write;
    logic       cur_ack;
    int         cur_base;
    logic [7:0] cur_rbyte;
    logic       timeout;

    always #2.5 clk = ~clk;

    assign line = sda_drive ? sda_out : slave_q;

    always_comb begin
        slave_q = 1'b1;
        if (active) begin
            if (cur_read && slave_idx >= cur_base && slave_idx < cur_base + 8)
                slave_q = cur_rbyte[7 - (slave_idx - cur_base)];
            else if (cur_write && slave_idx == cur_base + 8)
                slave_q = cur_ack;
        end
    end

    i2c_byte_engine #(.PERIOD(P), .BITS(8)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_req     (op_req),
        .op_flags   (op_flags),
        .tx_byte    (tx_byte),
        .op_done    (op_done),
        .rx_byte    (rx_byte),
        .slave_nack (slave_nack),
        .scl_o      (scl_o),
        .sda_in     (line),
        .sda_out    (sda_out),
        .sda_drive  (sda_drive)
    );

    // bus monitor, samples 1 ns after each rising clock edge
    always @(posedge clk) begin
        #1;
        if (mon_clear) begin
            rc = 0; slave_idx = 0; n_start = 0; n_stop = 0; hi_len = 0; hi_bad = 0;
        end else begin
            if (scl_o && !prev_scl) begin
                if (rc < 16) begin
                    bits_seen[rc] = line;
                    oe_seen[rc]   = sda_drive;
                end
                rc = rc + 1;
                hi_len = 1;
            end else if (scl_o && prev_scl) begin
                hi_len = hi_len + 1;
                if (prev_line && !line) n_start = n_start + 1;
                if (!prev_line && line) n_stop = n_stop + 1;
            end else if (!scl_o && prev_scl) begin
                if (active && hi_len != HALF) hi_bad = hi_bad + 1;
                slave_idx = rc;
            end
        end
        prev_scl  = scl_o;
        prev_line = line;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] fl, input logic [7:0] wb,
                          input logic [7:0] rb, input logic ackv, input bit inject);
        logic ok_cmd;
        logic s;
        logic p;
        logic scl_before;
        int   n;
        int   cycles;
        bit   seen;
        ok_cmd = fl[1] | fl[2];
        s = fl[0];
        p = fl[3];
        n = (int'(s) + 9 + int'(p)) * P;
        @(negedge clk);
        scl_before = scl_o;
        op_flags  = fl;
        tx_byte   = wb;
        op_req    = 1'b1;
        mon_clear = 1'b1;
        active    = 1'b0;
        cur_base  = int'(s);
        cur_write = fl[1];
        cur_read  = !fl[1] && fl[2];
        cur_rbyte = rb;
        cur_ack   = ackv;
        @(negedge clk);
        op_req    = 1'b0;
        mon_clear = 1'b0;
        if (!ok_cmd) begin
            seen = 0;
            for (int k = 0; k < 3 * P; k++) begin
                @(negedge clk);
                if (op_done) seen = 1;
            end
            check($sformatf("R2 flags %h refused: done seen", fl), int'(seen), 0);
            check($sformatf("R2 flags %h refused: scl held", fl), int'(scl_o), int'(scl_before));
            return;
        end
        active = 1'b1;
        cycles = 0;
        while (!op_done && cycles < 20 * P) begin
            @(negedge clk);
            cycles++;
            if (inject && cycles == 2 * P + 3) begin
                op_req   = 1'b1;
                op_flags = ~fl | 4'b0110;
                tx_byte  = ~wb;
            end else begin
                op_req = 1'b0;
            end
        end
        op_req = 1'b0;
        check($sformatf("R4 flags %h latency", fl), cycles, n);
        @(negedge clk);
        check("R4 done pulse one cycle", int'(op_done), 0);
        active = 1'b0;
        check($sformatf("R5 flags %h clock pulses", fl), rc, n / P);
        check("R5 clock high width", hi_bad, 0);
        check($sformatf("R5 flags %h clock level after", fl), int'(scl_o), int'(p));
        check($sformatf("R6 flags %h start edges", fl), n_start, int'(s));
        check($sformatf("R6 flags %h stop edges", fl), n_stop, int'(p));
        if (fl[1]) begin
            for (int j = 0; j < 8; j++) begin
                check($sformatf("R7 flags %h write bit %0d", fl, j),
                      int'(bits_seen[cur_base + j]), int'(wb[7 - j]));
                check("R7 write bit driven", int'(oe_seen[cur_base + j]), 1);
            end
            if (fl[2]) check("R2 write wins over read", int'(oe_seen[cur_base]), 1);
            check("R8 ack bit released", int'(oe_seen[cur_base + 8]), 0);
            check($sformatf("R8 flags %h slave ack", fl), int'(slave_nack), int'(ackv));
        end else begin
            for (int j = 0; j < 8; j++)
                check("R9 read bit released", int'(oe_seen[cur_base + j]), 0);
            check($sformatf("R9 flags %h read byte", fl), int'(rx_byte), int'(rb));
            check("R10 master ack driven", int'(oe_seen[cur_base + 8]), 1);
            check($sformatf("R10 flags %h master ack value", fl),
                  int'(bits_seen[cur_base + 8]), int'(p));
        end
        if (inject) check("R3 busy request left no trace", int'(op_done), 0);
    endtask

    task automatic run_all();
        for (int f = 0; f < 16; f++) begin
            for (int pat = 0; pat < 3; pat++) begin
                logic [7:0] wb;
                logic [7:0] rb;
                wb = 8'(f * 37 + pat * 91 + 5);
                rb = wb ^ 8'hA5 ^ 8'(pat * 60);
                run_op(4'(f), wb, rb, pat[0], pat == 1);
            end
        end
        // corner bytes
        run_op(4'b1011, 8'h00, 8'h00, 1'b0, 1'b0);
        run_op(4'b0010, 8'hFF, 8'h00, 1'b1, 1'b0);
        run_op(4'b0101, 8'h00, 8'hFF, 1'b0, 1'b0);
        run_op(4'b1100, 8'h00, 8'h01, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; op_req = 1'b0; op_flags = '0; tx_byte = '0;
        mon_clear = 1'b1; active = 1'b0; cur_read = 1'b0; cur_write = 1'b0;
        cur_ack = 1'b1; cur_base = 0; cur_rbyte = '0; timeout = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset scl", int'(scl_o), 1);
        check("R1 reset drive", int'(sda_drive), 0);
        check("R1 reset sda", int'(sda_out), 1);
        check("R1 reset done", int'(op_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release scl", int'(scl_o), 1);
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule